// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one character at a time into a serial frame on a single transmit line. A frame is a low start bit, then 5 to 9 data bits with the least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. The data length, parity mode and stop count are inputs. They are captured together with the character when it is accepted, so each frame keeps one format from its first bit to its last.

Bit timing comes from one of two sources. In asynchronous mode, a one-cycle baud tick from an outside divider ends the current bit and starts the next one. In synchronous mode, an external serial clock is compared with its value from the previous system clock cycle. A polarity input chooses whether its rising or its falling edge advances the line. Characters arrive on a valid/ready handshake. A new character can be accepted during the final stop bit, so frames can follow each other with no idle gap.

Top module: `serial_frame_tx`

## Requirements
- R1: After a character is accepted, the line stays high until the next bit step. It is driven low for exactly one bit (the start bit) beginning in the cycle after that step.
- R2: The data bits follow the start bit, bit 0 first. The length comes from cfg_len_sel: 0→5, 1→6, 2→7, 3→8, and 4 to 7→9 bits. Data bits above the selected length have no effect on the line.
- R3: cfg_parity[1]=1 inserts a parity bit right after the last data bit. cfg_parity[0]=0 selects even parity, which is the XOR of the used data bits. cfg_parity[0]=1 selects odd parity, which is the inverse. cfg_parity[1]=0 means no parity bit.
- R4: The frame ends with one high stop bit, or two when cfg_two_stop=1.
- R5: Out of reset, and whenever no frame is pending or being sent, tx_line is 1 and busy is 0.
- R6: A character accepted during the final stop bit starts its start bit at the step that ends that stop bit. If the acceptance and that step fall in the same cycle, the start bit begins in the next cycle.
- R7: With cfg_sync=0, a cycle with baud_tick=1 is a bit step. The line changes only in the cycle after a bit step.
- R8: With cfg_sync=1, baud_tick is ignored. A bit step is a cycle in which sclk differs from its value in the previous cycle: a 0→1 change when cfg_pol=0, and a 1→0 change when cfg_pol=1.
- R9: The data and format inputs are sampled only at acceptance. Changing them later does not alter the frame in progress.
- R10: in_ready is 1 only while idle or during the final stop bit. busy is 1 from the cycle after acceptance until the last stop bit ends with no new character accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character can be taken this cycle |
| in_data | input | MAX_LEN (9) | Character, bit 0 sent first |
| cfg_len_sel | input | 3 | Data length select (see R2) |
| cfg_parity | input | 2 | Bit 1 enables parity, bit 0 selects odd |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_sync | input | 1 | 1 selects synchronous (external clock) timing |
| cfg_pol | input | 1 | Synchronous edge: 0 rising, 1 falling |
| baud_tick | input | 1 | One-cycle bit pulse for asynchronous mode |
| sclk | input | 1 | External serial clock, sampled by clk |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame pending or in progress |

## Verification
The case that needs care is a handshake acceptance and a bit step in the same cycle while the final stop bit is on the line. The old frame must end and the new start bit must begin at once, with no extra idle bit and no lost character. The bench provokes this by raising in_valid only in cycles where baud_tick is high. A frame-level reference model judges the result cycle by cycle. The bench also requires that the simultaneous case actually occurred at least once.

// File: rtl/sft_pkg.sv
package sft_pkg;
    localparam int MIN_LEN = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2
    } tx_state_e;
endpackage

// File: rtl/sft_step_gen.sv
module sft_step_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mode,
    input  logic pol,
    input  logic baud_tick,
    input  logic sclk,
    output logic step
);
    typedef struct packed {
        logic sclk;
    } regs_t;

    regs_t r_d, r_q;
    logic  rise, fall;

    always_comb begin
        r_d      = r_q;
        r_d.sclk = sclk;
        rise     = sclk && !r_q.sclk;
        fall     = !sclk && r_q.sclk;
        if (sync_mode) begin
            step = pol ? fall : rise;
        end else begin
            step = baud_tick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R8: in synchronous mode a step needs a change of the external clock
    a_r8_step_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && step) |-> (sclk != r_q.sclk));
endmodule

// File: rtl/sft_frame_build.sv
module sft_frame_build #(
    parameter int MAX_LEN = 9,
    parameter int FW      = MAX_LEN + 4,
    parameter int CW      = $clog2(FW + 1)
) (
    input  logic [MAX_LEN-1:0] data,
    input  logic [2:0]         len_sel,
    input  logic [1:0]         par_mode,
    input  logic               two_stop,
    output logic [FW-1:0]      frame,
    output logic [CW-1:0]      nbits
);
    int   len;
    logic par;

    always_comb begin
        len = sft_pkg::MIN_LEN + int'(len_sel);
        if (len > MAX_LEN) begin
            len = MAX_LEN;
        end
        frame    = '1;
        frame[0] = 1'b0;
        par      = 1'b0;
        for (int i = 0; i < MAX_LEN; i++) begin
            if (i < len) begin
                frame[1+i] = data[i];
                par        = par ^ data[i];
            end
        end
        if (par_mode[1]) begin
            frame[1+len] = par ^ par_mode[0];
        end
        nbits = CW'(1 + len + (par_mode[1] ? 1 : 0) + (two_stop ? 2 : 1));
    end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
    parameter int MAX_LEN = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [MAX_LEN-1:0] in_data,
    input  logic [2:0]         cfg_len_sel,
    input  logic [1:0]         cfg_parity,
    input  logic               cfg_two_stop,
    input  logic               cfg_sync,
    input  logic               cfg_pol,
    input  logic               baud_tick,
    input  logic               sclk,
    output logic               tx_line,
    output logic               busy
);
    import sft_pkg::*;

    localparam int FW = MAX_LEN + 4;
    localparam int CW = $clog2(FW + 1);

    typedef struct packed {
        tx_state_e     st;
        logic [FW-1:0] sh;
        logic [CW-1:0] cnt;
        logic          tx;
    } regs_t;

    regs_t         r_d, r_q;
    logic          step;
    logic [FW-1:0] new_frame;
    logic [CW-1:0] new_nbits;
    logic          accept;
    logic          last_bit;

    sft_step_gen u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (cfg_sync),
        .pol       (cfg_pol),
        .baud_tick (baud_tick),
        .sclk      (sclk),
        .step      (step)
    );

    sft_frame_build #(
        .MAX_LEN (MAX_LEN),
        .FW      (FW),
        .CW      (CW)
    ) u_build (
        .data     (in_data),
        .len_sel  (cfg_len_sel),
        .par_mode (cfg_parity),
        .two_stop (cfg_two_stop),
        .frame    (new_frame),
        .nbits    (new_nbits)
    );

    always_comb begin
        r_d      = r_q;
        last_bit = (r_q.st == ST_SEND) && (r_q.cnt == CW'(1));
        in_ready = (r_q.st == ST_IDLE) || last_bit;
        accept   = in_valid && in_ready;
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.st  = ST_ARMED;
                    r_d.sh  = new_frame;
                    r_d.cnt = new_nbits;
                end
            end
            ST_ARMED: begin
                if (step) begin
                    r_d.st = ST_SEND;
                end
            end
            ST_SEND: begin
                if (step) begin
                    if (last_bit) begin
                        if (accept) begin
                            r_d.sh  = new_frame;
                            r_d.cnt = new_nbits;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end else begin
                        r_d.sh  = {1'b1, r_q.sh[FW-1:1]};
                        r_d.cnt = r_q.cnt - CW'(1);
                    end
                end else if (accept) begin
                    r_d.st  = ST_ARMED;
                    r_d.sh  = new_frame;
                    r_d.cnt = new_nbits;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
        r_d.tx = (r_d.st == ST_SEND) ? r_d.sh[0] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.sh  <= '1;
            r_q.cnt <= '0;
            r_q.tx  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_line = r_q.tx;
    assign busy    = (r_q.st != ST_IDLE);

    // R1: the step that leaves the waiting state puts the start bit on the line
    a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_ARMED && step) |=> !tx_line);

    // R4: the final bit of every frame is a high stop bit
    a_r4_last_high: assert property (@(posedge clk) disable iff (!rst_n)
        last_bit |-> tx_line);

    // R5: an idle block holds the line high
    a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line);

    // R7: the line only moves in the cycle after a bit step
    a_r7_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(tx_line));

    // R10: readiness while busy happens only on a high stop bit
    a_r10_ready_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && busy) |-> tx_line);

    // R10: an accepted character makes the block busy in the next cycle
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);
endmodule

// File: tb/sim_serial_frame_tx.sv
module sim_serial_frame_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [8:0] in_data = '0;
    logic [2:0] cfg_len_sel = '0;
    logic [1:0] cfg_parity = '0;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_sync = 1'b0;
    logic       cfg_pol = 1'b0;
    logic       baud_tick = 1'b0;
    logic       sclk = 1'b0;
    logic       tx_line;
    logic       busy;

    always #2 clk = ~clk;

    serial_frame_tx #(.MAX_LEN(9)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_data      (in_data),
        .cfg_len_sel  (cfg_len_sel),
        .cfg_parity   (cfg_parity),
        .cfg_two_stop (cfg_two_stop),
        .cfg_sync     (cfg_sync),
        .cfg_pol      (cfg_pol),
        .baud_tick    (baud_tick),
        .sclk         (sclk),
        .tx_line      (tx_line),
        .busy         (busy)
    );

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    string       cur_req = "R5";

    typedef int iq_t[$];

    // reference model state
    iq_t  m_q;
    iq_t  m_pend;
    iq_t  m_nf;
    bit   m_armed = 0;
    bit   m_prev_sclk = 0;
    bit   m_acc = 0;
    bit   m_step;
    bit   m_rdy;
    int   coinc = 0;

    // stimulus generator controls
    int   cyc = 0;
    bit   tick_en = 0;
    int   tick_div = 4;
    bit   sclk_en = 0;
    int   sclk_half = 3;
    int   wd = 0;

    function automatic iq_t build_frame(input logic [8:0] d, input logic [2:0] ls,
                                        input logic [1:0] pm, input logic two);
        iq_t o;
        int  n;
        int  p;
        n = (ls >= 3'd4) ? 9 : 5 + int'(ls);
        p = 0;
        o.push_back(0);
        for (int i = 0; i < n; i++) begin
            o.push_back(int'(d[i]));
            p = p ^ int'(d[i]);
        end
        if (pm[1]) o.push_back(pm[0] ? 1 - p : p);
        o.push_back(1);
        if (two) o.push_back(1);
        return o;
    endfunction

    task automatic check_bit(input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", cur_req, what, act, exp, cyc);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            m_pend.delete();
            m_armed     = 0;
            m_prev_sclk = 0;
            m_acc       = 0;
        end else begin
            if (cfg_sync) m_step = cfg_pol ? (m_prev_sclk && !sclk) : (!m_prev_sclk && sclk);
            else          m_step = baud_tick;
            m_rdy = (!m_armed && m_q.size() == 0) || (m_q.size() == 1);
            m_acc = in_valid && m_rdy;
            if (m_acc) m_nf = build_frame(in_data, cfg_len_sel, cfg_parity, cfg_two_stop);
            if (m_q.size() > 0) begin
                if (m_step) begin
                    void'(m_q.pop_front());
                    if (m_q.size() == 0 && m_acc) begin
                        m_q = m_nf;
                        coinc++;
                    end
                end else if (m_acc) begin
                    m_q.delete();
                    m_pend  = m_nf;
                    m_armed = 1;
                end
            end else if (m_armed) begin
                if (m_step) begin
                    m_q     = m_pend;
                    m_armed = 0;
                end
            end else if (m_acc) begin
                m_pend  = m_nf;
                m_armed = 1;
            end
            m_prev_sclk = sclk;
        end
    end

    // compare against the model away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check_bit("tx_line", tx_line, (m_q.size() > 0) ? logic'(m_q[0]) : 1'b1);
            check_bit("busy", busy, m_armed || (m_q.size() > 0));
            check_bit("in_ready", in_ready, (!m_armed && m_q.size() == 0) || (m_q.size() == 1));
        end
    end

    // baud tick and external clock generators
    always @(negedge clk) begin
        cyc++;
        baud_tick <= tick_en && (cyc % tick_div == 0);
        if (sclk_en && (cyc % sclk_half == 0)) sclk <= ~sclk;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual %0d cycles expected below %0d", wd, 150000);
            summary();
            $finish;
        end
    end

    // R9: after acceptance the character and format inputs are scrambled
    task automatic send(input logic [8:0] d, input logic [2:0] ls, input logic [1:0] pm,
                        input logic two, input bit tick_only);
        do begin
            @(negedge clk);
            #1;
            in_valid     = !tick_only || baud_tick;
            in_data      = d;
            cfg_len_sel  = ls;
            cfg_parity   = pm;
            cfg_two_stop = two;
            @(posedge clk);
            #1;
        end while (!m_acc);
        @(negedge clk);
        #1;
        in_valid     = 1'b0;
        in_data      = 9'($urandom);
        cfg_len_sel  = 3'($urandom);
        cfg_parity   = 2'($urandom);
        cfg_two_stop = 1'($urandom);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int sweep;
        // R5: reset state
        repeat (4) @(negedge clk);
        check_bit("reset tx_line", tx_line, 1'b1);
        check_bit("reset busy", busy, 1'b0);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 R2 R3 R4 R7 R9 R10: all 30 formats, asynchronous timing
        cur_req  = "R1 R2 R3 R4 R7 R9 R10";
        tick_en  = 1;
        tick_div = 4;
        sweep    = 0;
        for (int ls = 0; ls < 5; ls++) begin
            for (int pm = 1; pm < 4; pm++) begin
                for (int two = 0; two < 2; two++) begin
                    send(9'(9'h1A5 ^ (sweep * 37)), 3'(ls), 2'(pm), 1'(two), 0);
                    if (sweep % 5 == 0) wait_idle();
                    sweep++;
                end
            end
        end
        // R2: upper bits set beyond a 5-bit length, length codes 5..7 map to 9 bits
        send(9'h1E0, 3'd0, 2'd2, 1'b0, 0);
        send(9'h1FF, 3'd7, 2'd3, 1'b1, 0);
        send(9'h0C3, 3'd5, 2'd0, 1'b0, 0);
        wait_idle();

        // R6: acceptance in the same cycle as the step ending the stop bit
        cur_req  = "R6";
        tick_div = 5;
        for (int k = 0; k < 6; k++) send(9'(k * 71 + 5), 3'(k % 5), 2'(k % 4), 1'(k % 2), 1);
        wait_idle();
        n_chk++;
        if (coinc == 0) begin
            n_fail++;
            $display("FAIL R6 coincident accept: actual %0d events expected above 0", coinc);
        end

        // R8: synchronous timing, rising then falling edges; baud_tick keeps running
        cur_req  = "R8";
        sclk_en  = 1;
        cfg_sync = 1;
        cfg_pol  = 0;
        for (int k = 0; k < 6; k++) send(9'(k * 53 + 9), 3'(4 - k % 5), 2'(3 - k % 4), 1'(k % 2), 0);
        wait_idle();
        cfg_pol = 1;
        for (int k = 0; k < 6; k++) send(9'(k * 97 + 3), 3'(k % 5), 2'(k % 4), 1'((k + 1) % 2), 0);
        wait_idle();

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end
endmodule